// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside the execute stage of a processor core and handles the entry into an exception or interrupt handler. Each cycle it looks at two things: a pending synchronous fault, given as a 12-bit event code, and a pending external interrupt. It picks at most one of them. On the next clock edge it saves the processor context, writes the event code, builds the new status word and computes the handler address. The handler address depends on the class of the event.

The status word `sr_in` uses these fields:

- bit 28 is the blocked flag
- bit 29 is the register-bank flag
- bit 30 is the privileged-mode flag
- bit 15 is the floating-point-disable flag
- bits 7:4 hold the interrupt mask level

The delay-slot flag input has four bits:

- bit 0: in an unconditional delay slot
- bit 1: in a conditional delay slot
- bit 2: branch-taken marker
- bit 3: clear-all marker

The block does not own the interrupt controller. It presents the current mask level on `irq_mask_level` and gets back either a vector or "none" in the same cycle. All outputs are registered. They change only on the edge where an event is accepted, and `taken` is high for the one cycle after that edge.

Top module: `exc_entry_seq`

## Requirements
- R1: When `exc_valid` and `irq_req` are high in the same cycle, the exception is taken. `expevt` receives its code and `intevt` keeps its old value.
- R2: While `sr_in[28]` is set, an exception whose code is not 0x1E0 is taken as code 0x000, with the matching reset-class vectoring. Code 0x1E0 keeps its own code.
- R3: While `sr_in[28]` is set, an interrupt (with no exception pending) is ignored unless `halt_wake` is high. In that case `halt_clr` pulses for one cycle and the interrupt may be taken.
- R4: On entry, `ssr`, `spc` (before adjustment) and `sgr` capture `sr_in`, `pc_in` and `r15_in`. The new status word has bits 28, 29 and 30 set.
- R5: If flag bit 0 or bit 1 is set on entry, `spc` is `pc_in - 2`, and flag bits 2:0 are cleared in `dslot_out`.
- R6: If flag bit 3 is set on entry, `dslot_out` becomes 0.
- R7: Codes 0x000, 0x020 and 0x140 clear status bit 15, set status bits 7:4 to 0xF, and set `pc_out` to 0xA0000000.
- R8: Codes 0x040 and 0x060 vector to `vbr_in + 0x400`. Every other exception code vectors to `vbr_in + 0x100`.
- R9: Code 0x160 adds 2 to the saved `spc`, after any delay-slot rewind.
- R10: An interrupt is taken only when the controller answers `irq_vec_valid` for mask level `sr_in[7:4]`. It writes `irq_vec` to `intevt` and vectors to `vbr_in + 0x600`. An answer of "none" changes nothing.
- R11: `taken` is high for exactly the cycle after an accepted event. Without an accepted event no output register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_valid | input | 1 | Synchronous exception pending |
| exc_code | input | 12 | Pending exception event code |
| irq_req | input | 1 | External interrupt pending |
| irq_vec_valid | input | 1 | Controller has an unmasked vector at the current level |
| irq_vec | input | 12 | Interrupt vector from the controller |
| irq_mask_level | output | 4 | Current mask level presented to the controller |
| sr_in | input | 32 | Current status word |
| pc_in | input | 32 | Program counter of the faulting or interrupted instruction |
| r15_in | input | 32 | General register 15 |
| vbr_in | input | 32 | Vector base |
| halt_wake | input | 1 | Core is waking from halt |
| dslot_in | input | 4 | Delay-slot flags |
| taken | output | 1 | One-cycle entry strobe |
| halt_clr | output | 1 | One-cycle request to clear the halt-wake flag |
| ssr | output | 32 | Saved status word |
| spc | output | 32 | Saved program counter |
| sgr | output | 32 | Saved register 15 |
| expevt | output | 12 | Exception event code |
| intevt | output | 12 | Interrupt event code |
| sr_out | output | 32 | New status word |
| pc_out | output | 32 | Handler address |
| dslot_out | output | 4 | Delay-slot flags after entry |

## Verification
A wrong decision shows at the ports one cycle after the inputs, because every output is a register loaded on the accepting edge.

- A priority or blocking error shows as a wrong `expevt`, a wrong `intevt` or a stray `taken`.
- A vectoring error shows as a wrong `pc_out` or `sr_out`.
- A rewind error shows as a `spc` that is off by two.

An event that is dropped leaves every output at its previous value. For that reason the bench compares every output against its own model on every cycle, not only after expected entries.

// File: rtl/exc_entry_pkg.sv
// Package: shared constants for the exception entry sequencer.
// Assumes a 32-bit status word with fixed field positions.
package exc_entry_pkg;
    localparam int CODE_W  = 12;
    localparam int FLAG_W  = 4;

    // Status word field positions
    localparam int SR_BLOCK = 28;
    localparam int SR_BANK  = 29;
    localparam int SR_PRIV  = 30;
    localparam int SR_FPOFF = 15;
    localparam int SR_MLSB  = 4;

    // Delay-slot flag positions
    localparam int DS_UNCOND = 0;
    localparam int DS_COND   = 1;
    localparam int DS_TAKEN  = 2;
    localparam int DS_WIPE   = 3;

    // Event codes with special handling
    localparam logic [CODE_W-1:0] EV_RESET   = 12'h000;
    localparam logic [CODE_W-1:0] EV_MRESET  = 12'h020;
    localparam logic [CODE_W-1:0] EV_MULTHIT = 12'h140;
    localparam logic [CODE_W-1:0] EV_TLB_RD  = 12'h040;
    localparam logic [CODE_W-1:0] EV_TLB_WR  = 12'h060;
    localparam logic [CODE_W-1:0] EV_TRAP    = 12'h160;
    localparam logic [CODE_W-1:0] EV_UNBLK   = 12'h1E0;

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_EXC  = 2'd1,
        PICK_IRQ  = 2'd2
    } pick_e;
endpackage

// File: rtl/exc_arbiter.sv
// Module: exc_arbiter
// Chooses between a pending exception and a pending interrupt.
// Applies the blocked-state substitution of the event code.
// Assumes the interrupt controller answers in the same cycle.
module exc_arbiter
    import exc_entry_pkg::*;
(
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic              irq_vec_valid,
    input  logic              blocked,
    input  logic              halt_wake,
    output pick_e             pick,
    output logic [CODE_W-1:0] eff_code,
    output logic              halt_clr
);
    logic irq_alone;

    // Priority decision: an exception always wins over an interrupt.
    always_comb begin
        irq_alone = irq_req && !exc_valid;
        halt_clr  = irq_alone && blocked && halt_wake;
        eff_code  = (blocked && exc_code != EV_UNBLK) ? EV_RESET : exc_code;
        if (exc_valid)
            pick = PICK_EXC;
        else if (irq_alone && (!blocked || halt_wake) && irq_vec_valid)
            pick = PICK_IRQ;
        else
            pick = PICK_NONE;
    end
endmodule

// File: rtl/exc_target.sv
// Module: exc_target
// Builds the new status word and handler address for the chosen event.
// Assumes XLEN >= 32 so that the status field positions exist.
module exc_target
    import exc_entry_pkg::*;
#(
    parameter int               XLEN     = 32,
    parameter logic [XLEN-1:0]  RESET_PC = 32'hA000_0000,
    parameter int               OFS_GEN  = 'h100,
    parameter int               OFS_TLB  = 'h400,
    parameter int               OFS_IRQ  = 'h600
)(
    input  pick_e             pick,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   vbr_in,
    output logic [XLEN-1:0]   sr_next,
    output logic [XLEN-1:0]   pc_next
);
    logic reset_class;
    logic tlb_class;

    // Class decode of the event code.
    always_comb begin
        reset_class = (code == EV_RESET) || (code == EV_MRESET) || (code == EV_MULTHIT);
        tlb_class   = (code == EV_TLB_RD) || (code == EV_TLB_WR);
    end

    // Status and vector selection by event kind and class.
    always_comb begin
        sr_next = sr_in;
        pc_next = pc_in;
        if (pick != PICK_NONE) begin
            sr_next[SR_BLOCK] = 1'b1;
            sr_next[SR_BANK]  = 1'b1;
            sr_next[SR_PRIV]  = 1'b1;
        end
        case (pick)
            PICK_EXC: begin
                if (reset_class) begin
                    sr_next[SR_FPOFF]           = 1'b0;
                    sr_next[SR_MLSB+3:SR_MLSB]  = 4'hF;
                    pc_next                     = RESET_PC;
                end else if (tlb_class) begin
                    pc_next = vbr_in + XLEN'(OFS_TLB);
                end else begin
                    pc_next = vbr_in + XLEN'(OFS_GEN);
                end
            end
            PICK_IRQ: pc_next = vbr_in + XLEN'(OFS_IRQ);
            default:  ;
        endcase
    end
endmodule

// File: rtl/exc_ctx_adjust.sv
// Module: exc_ctx_adjust
// Computes the saved PC (delay-slot rewind, trap advance) and the flags after entry.
// Assumes instructions are 2 bytes long.
module exc_ctx_adjust
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
)(
    input  pick_e             pick,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [XLEN-1:0]   spc_next,
    output logic [FLAG_W-1:0] flags_next
);
    logic in_slot;
    logic is_trap;

    // Saved-PC arithmetic and flag cleanup.
    always_comb begin
        in_slot  = flags_in[DS_UNCOND] || flags_in[DS_COND];
        is_trap  = (pick == PICK_EXC) && (code == EV_TRAP);
        spc_next = pc_in - (in_slot ? XLEN'(2) : XLEN'(0)) + (is_trap ? XLEN'(2) : XLEN'(0));
        flags_next = flags_in;
        if (in_slot) begin
            flags_next[DS_UNCOND] = 1'b0;
            flags_next[DS_COND]   = 1'b0;
            flags_next[DS_TAKEN]  = 1'b0;
        end
        if (flags_in[DS_WIPE])
            flags_next = '0;
    end
endmodule

// File: rtl/exc_entry_seq.sv
// Module: exc_entry_seq (top)
// Accepts one exception or interrupt per clock.
// Registers the saved context, event codes, new status word and handler address.
// Assumes a synchronous active-low reset. Outputs hold their values between entries.
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000,
    parameter int              OFS_GEN  = 'h100,
    parameter int              OFS_TLB  = 'h400,
    parameter int              OFS_IRQ  = 'h600
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [11:0]       exc_code,
    input  logic              irq_req,
    input  logic              irq_vec_valid,
    input  logic [11:0]       irq_vec,
    output logic [3:0]        irq_mask_level,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   r15_in,
    input  logic [XLEN-1:0]   vbr_in,
    input  logic              halt_wake,
    input  logic [3:0]        dslot_in,
    output logic              taken,
    output logic              halt_clr,
    output logic [XLEN-1:0]   ssr,
    output logic [XLEN-1:0]   spc,
    output logic [XLEN-1:0]   sgr,
    output logic [11:0]       expevt,
    output logic [11:0]       intevt,
    output logic [XLEN-1:0]   sr_out,
    output logic [XLEN-1:0]   pc_out,
    output logic [3:0]        dslot_out
);
    pick_e             pick;
    logic [CODE_W-1:0] eff_code;
    logic              halt_clr_c;
    logic [XLEN-1:0]   sr_next, pc_next, spc_next;
    logic [FLAG_W-1:0] flags_next;

    assign irq_mask_level = sr_in[SR_MLSB+3:SR_MLSB];

    exc_arbiter u_arb (
        .exc_valid     (exc_valid),
        .exc_code      (exc_code),
        .irq_req       (irq_req),
        .irq_vec_valid (irq_vec_valid),
        .blocked       (sr_in[SR_BLOCK]),
        .halt_wake     (halt_wake),
        .pick          (pick),
        .eff_code      (eff_code),
        .halt_clr      (halt_clr_c)
    );

    exc_target #(
        .XLEN(XLEN), .RESET_PC(RESET_PC),
        .OFS_GEN(OFS_GEN), .OFS_TLB(OFS_TLB), .OFS_IRQ(OFS_IRQ)
    ) u_tgt (
        .pick    (pick),
        .code    (eff_code),
        .sr_in   (sr_in),
        .pc_in   (pc_in),
        .vbr_in  (vbr_in),
        .sr_next (sr_next),
        .pc_next (pc_next)
    );

    exc_ctx_adjust #(.XLEN(XLEN)) u_ctx (
        .pick       (pick),
        .code       (eff_code),
        .pc_in      (pc_in),
        .flags_in   (dslot_in),
        .spc_next   (spc_next),
        .flags_next (flags_next)
    );

    // Strobes: entry accepted, halt-wake clear request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken    <= 1'b0;
            halt_clr <= 1'b0;
        end else begin
            taken    <= (pick != PICK_NONE);
            halt_clr <= halt_clr_c;
        end
    end

    // Context registers: loaded only when an event is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ssr       <= '0;
            spc       <= '0;
            sgr       <= '0;
            expevt    <= '0;
            intevt    <= '0;
            sr_out    <= '0;
            pc_out    <= '0;
            dslot_out <= '0;
        end else if (pick != PICK_NONE) begin
            ssr       <= sr_in;
            spc       <= spc_next;
            sgr       <= r15_in;
            sr_out    <= sr_next;
            pc_out    <= pc_next;
            dslot_out <= flags_next;
            if (pick == PICK_EXC) expevt <= eff_code;
            else                  intevt <= irq_vec;
        end
    end

    // R1: a pending exception is always accepted and leaves intevt alone
    a_r1_exc_wins: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> taken && $stable(intevt));

    // R2: blocked state turns ordinary codes into the reset code
    a_r2_blocked_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && sr_in[SR_BLOCK] && exc_code != EV_UNBLK)
        |=> (expevt == EV_RESET) && (pc_out == RESET_PC));

    // R3: blocked interrupt without wake is not taken
    a_r3_blocked_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !exc_valid && sr_in[SR_BLOCK] && !halt_wake) |=> !taken);

    // R4: context capture and status bits on entry
    a_r4_ctx_save: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (sgr == $past(r15_in)) && (ssr == $past(sr_in))
                  && sr_out[SR_BLOCK] && sr_out[SR_BANK] && sr_out[SR_PRIV]);

    // R10: an unblocked interrupt with a vector goes to the interrupt offset
    a_r10_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !exc_valid && irq_vec_valid && !sr_in[SR_BLOCK])
        |=> (pc_out == $past(vbr_in) + XLEN'(OFS_IRQ)) && (intevt == $past(irq_vec)));

    // R11: without an entry nothing changes
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> $stable(pc_out) && $stable(sr_out) && $stable(spc) && $stable(expevt));
endmodule

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 0, irq_req = 0, irq_vec_valid = 0, halt_wake = 0;
    logic [11:0] exc_code = 0, irq_vec = 0;
    logic [31:0] sr_in = 0, pc_in = 0, r15_in = 0, vbr_in = 0;
    logic [3:0]  dslot_in = 0;
    logic [3:0]  irq_mask_level;
    logic        taken, halt_clr;
    logic [31:0] ssr, spc, sgr, sr_out, pc_out;
    logic [11:0] expevt, intevt;
    logic [3:0]  dslot_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected state
    logic        e_taken, e_hclr;
    logic [31:0] e_ssr, e_spc, e_sgr, e_sr, e_pc;
    logic [11:0] e_exp, e_int;
    logic [3:0]  e_ds;

    always #2.5 clk = ~clk;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
        .irq_req(irq_req), .irq_vec_valid(irq_vec_valid), .irq_vec(irq_vec),
        .irq_mask_level(irq_mask_level), .sr_in(sr_in), .pc_in(pc_in),
        .r15_in(r15_in), .vbr_in(vbr_in), .halt_wake(halt_wake), .dslot_in(dslot_in),
        .taken(taken), .halt_clr(halt_clr), .ssr(ssr), .spc(spc), .sgr(sgr),
        .expevt(expevt), .intevt(intevt), .sr_out(sr_out), .pc_out(pc_out),
        .dslot_out(dslot_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic is_reset_class(input logic [11:0] c);
        return c == 12'h000 || c == 12'h020 || c == 12'h140;
    endfunction

    // Model of one clock edge from the requirements
    task automatic predict();
        logic blk, slot, do_exc, do_irq;
        logic [11:0] code;
        blk    = sr_in[28];
        do_exc = exc_valid;
        do_irq = !exc_valid && irq_req && (!blk || halt_wake) && irq_vec_valid;
        e_hclr = !exc_valid && irq_req && blk && halt_wake;
        e_taken = do_exc || do_irq;
        code   = (blk && exc_code != 12'h1E0) ? 12'h000 : exc_code;
        if (e_taken) begin
            slot  = dslot_in[0] | dslot_in[1];
            e_ssr = sr_in;
            e_sgr = r15_in;
            e_spc = pc_in - (slot ? 32'd2 : 32'd0);
            if (do_exc && code == 12'h160) e_spc = e_spc + 32'd2;
            e_ds = dslot_in;
            if (slot) e_ds[2:0] = 3'b000;
            if (dslot_in[3]) e_ds = 4'h0;
            e_sr = sr_in | 32'h7000_0000;
            if (do_exc) begin
                e_exp = code;
                if (is_reset_class(code)) begin
                    e_sr[15] = 1'b0; e_sr[7:4] = 4'hF; e_pc = 32'hA000_0000;
                end else if (code == 12'h040 || code == 12'h060)
                    e_pc = vbr_in + 32'h400;
                else
                    e_pc = vbr_in + 32'h100;
            end else begin
                e_int = irq_vec;
                e_pc  = vbr_in + 32'h600;
            end
        end
    endtask

    task automatic check_all();
        chk("R11 taken", {31'd0, taken}, {31'd0, e_taken});
        chk("R3 halt_clr", {31'd0, halt_clr}, {31'd0, e_hclr});
        chk("R4 ssr", ssr, e_ssr);
        chk("R4 sgr", sgr, e_sgr);
        chk("R5 spc", spc, e_spc);
        chk("R2 expevt", {20'd0, expevt}, {20'd0, e_exp});
        chk("R10 intevt", {20'd0, intevt}, {20'd0, e_int});
        chk("R7 sr_out", sr_out, e_sr);
        chk("R8 pc_out", pc_out, e_pc);
        chk("R6 dslot_out", {28'd0, dslot_out}, {28'd0, e_ds});
    endtask

    task automatic step();
        chk("R10 mask level", {28'd0, irq_mask_level}, {28'd0, sr_in[7:4]});
        predict();
        @(negedge clk);
        check_all();
    endtask

    task automatic drive(input logic ev, input logic [11:0] c, input logic ir, input logic vv,
                         input logic [11:0] v, input logic [31:0] s, input logic [3:0] ds,
                         input logic hw);
        exc_valid = ev; exc_code = c; irq_req = ir; irq_vec_valid = vv; irq_vec = v;
        sr_in = s; dslot_in = ds; halt_wake = hw;
        pc_in = 32'h0C00_1000 + {$urandom % 32'h100, 1'b0};
        r15_in = $urandom; vbr_in = 32'h8000_0000 + {$urandom % 32'h1000, 8'h00};
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] codes [8];
        codes = '{12'h000, 12'h020, 12'h040, 12'h060, 12'h0A0, 12'h140, 12'h160, 12'h1E0};
        void'($urandom(32'd20240607));
        e_taken = 0; e_hclr = 0; e_ssr = 0; e_spc = 0; e_sgr = 0; e_sr = 0; e_pc = 0;
        e_exp = 0; e_int = 0; e_ds = 0;
        repeat (3) @(negedge clk);
        check_all();                       // reset state (R11)
        rst_n = 1'b1;

        // R11: idle, nothing changes
        drive(0, 0, 0, 0, 0, 32'h0000_00F0, 0, 0); step();
        // R1: both pending, exception wins
        drive(1, 12'h0A0, 1, 1, 12'h320, 32'h0000_0010, 0, 0); step();
        chk("R1 expevt", {20'd0, expevt}, 32'h0A0);
        chk("R1 intevt unchanged", {20'd0, intevt}, 32'h0);
        // R2: blocked turns 0x0A0 into reset; 0x1E0 survives
        drive(1, 12'h0A0, 0, 0, 0, 32'h1000_8000, 0, 0); step();
        chk("R2 reset code", {20'd0, expevt}, 32'h000);
        drive(1, 12'h1E0, 0, 0, 0, 32'h1000_0000, 0, 0); step();
        chk("R2 unblockable code", {20'd0, expevt}, 32'h1E0);
        // R3: blocked irq without wake ignored; with wake taken and halt_clr
        drive(0, 0, 1, 1, 12'h400, 32'h1000_0000, 0, 0); step();
        chk("R3 ignored", {31'd0, taken}, 32'd0);
        drive(0, 0, 1, 1, 12'h420, 32'h1000_0000, 0, 1); step();
        chk("R3 wake taken", {31'd0, taken & halt_clr}, 32'd1);
        // R5 and R9: trap in a delay slot, net saved PC unchanged
        drive(1, 12'h160, 0, 0, 0, 32'h0, 4'b0101, 0); step();
        chk("R9 trap in slot", spc, pc_in);
        // R6: clear-all marker
        drive(1, 12'h100, 0, 0, 0, 32'h0, 4'b1110, 0); step();
        chk("R6 wipe", {28'd0, dslot_out}, 32'd0);
        // R7: 0x140 reset class
        drive(1, 12'h140, 0, 0, 0, 32'h0000_8030, 0, 0); step();
        chk("R7 reset class pc", pc_out, 32'hA000_0000);
        // R10: no vector answer leaves state alone
        drive(0, 0, 1, 0, 12'h600, 32'h0000_0050, 0, 0); step();
        chk("R10 none", {31'd0, taken}, 32'd0);
        // R8: TLB miss
        drive(1, 12'h060, 0, 0, 0, 32'h0, 0, 0); step();
        chk("R8 tlb vector", pc_out - vbr_in, 32'h400);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] s;
            s = $urandom;
            s[28] = ($urandom % 3 == 0);
            drive(($urandom % 2) == 0, codes[$urandom % 8], ($urandom % 2) == 0,
                  ($urandom % 4) != 0, 12'($urandom), s, 4'($urandom), ($urandom % 2) == 0);
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule